// File: doc/BRIEF.md
# Priority-Encoded Vectored Interrupt Controller

This block gathers thirteen level-sensitive interrupt requests, numbered 1 to 13, and presents one of them to the processor. It has three outputs to the processor: a 3-bit priority level, an 8-bit exception vector, and the register read data. A level of zero means that nothing is requested. Each source has an 8-bit control byte. The low five bits of that byte rank the source against the others. Bits 4:2 give the level the processor sees. Bit 7 picks how the vector is formed.

Software sets up the controller through a simple byte-addressed register port. Writes take effect on the clock edge where the write strobe is sampled, and reads are combinational. There is one mask bit per source. After reset every mask bit is set, so software must clear a source's mask bit before that source can be presented. The level/vector pair is registered. It follows the pending, mask and control state with a delay of one clock.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The pending bit of source i (bit i of the 16-bit word at byte address 0x3A) is the request input level sampled on the previous rising edge. Bits 0, 14 and 15 read as 0. A write to 0x3A changes nothing.
- R2: The mask word sits at 0x36, with bit i belonging to source i and 1 meaning masked. It resets to 0x3FFE. A masked source is never presented, even when it is pending.
- R3: Among pending, unmasked sources the controller picks the one with the largest control[4:0]. When two sources tie, the lower-numbered one wins.
- R4: If there is no active source, or the winner's control[4:0] is below 4, both the level output and the vector output are 0.
- R5: For a presented source, the level output equals control[4:2] of the winner.
- R6: When the winner's control bit 7 is 1, the vector is 24 plus the level.
- R7: When the winner's control bit 7 is 0, the vector is chosen by source: source 8 uses the watchdog vector register (0x40), source 12 uses the first serial vector register (0x41), source 13 uses the second serial vector register (0x42), and every other source uses 0x0F.
- R8: Control bytes for sources 1 to 13 sit at 0x14 to 0x20 in source order and are read and written on data bits 7:0. Their reset values are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00, 0x00. The three vector registers reset to 0x0F.
- R9: A register write changes the level/vector outputs on the rising edge that follows the write edge. A request change reaches the outputs on the second rising edge after the change.
- R10: A read from an address that maps to no register returns 0. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 13 | Level request inputs; bit i-1 is source i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational register read data |
| irq_level_o | output | 3 | Presented interrupt level, 0 when idle |
| irq_vector_o | output | 8 | Presented vector, 0 when idle |

## Verification
The first sweep drives one request at a time through every source with all 32 rank values, alternating control bit 7. This separates the threshold at 4, the level field and both vector paths for each source. The second sweep raises every pair of sources at equal rank and then at unequal rank, which tells the tie rule apart from plain largest-wins. Walking-mask patterns with all requests high show that masking removes a source and hands the grant to the next best one. The vector registers are rewritten with distinct values so that the per-source vector choice cannot be confused with the 0x0F fallback.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LVL_W = 3;
    localparam int VEC_W = 8;
    localparam int CTL_W = 8;

    typedef logic [CTL_W-1:0] ctl_t;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } irq_out_t;

    // Power-up control byte for a given source number
    function automatic ctl_t ctl_reset_value(input int src);
        if (src <= 7)       return ctl_t'(src * 4);
        else if (src == 8)  return ctl_t'(8'h1C);
        else if (src <= 11) return ctl_t'(8'h80);
        else                return ctl_t'(8'h00);
    endfunction

endpackage

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 13,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int CTL_BASE  = 'h14,
    parameter int MASK_ADDR = 'h36,
    parameter int PEND_ADDR = 'h3A,
    parameter int WVEC_ADDR = 'h40,
    parameter int SVEC0_ADDR = 'h41,
    parameter int SVEC1_ADDR = 'h42,
    parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC:1]              irq_req,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_SRC:1][CTL_W-1:0]   ctl_o,
    output logic [NUM_SRC:1]              mask_o,
    output logic [NUM_SRC:1]              pend_o,
    output logic [VEC_W-1:0]              wvec_o,
    output logic [VEC_W-1:0]              svec0_o,
    output logic [VEC_W-1:0]              svec1_o
);

    typedef struct packed {
        logic [NUM_SRC:1][CTL_W-1:0] ctl;
        logic [NUM_SRC:1]            mask;
        logic [NUM_SRC:1]            pend;
        logic [VEC_W-1:0]            wvec;
        logic [VEC_W-1:0]            svec0;
        logic [VEC_W-1:0]            svec1;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = irq_req;
        if (wr_en) begin
            for (int i = 1; i <= NUM_SRC; i++) begin
                if (addr == ADDR_W'(CTL_BASE + i - 1))
                    st_d.ctl[i] = wdata[CTL_W-1:0];
            end
            if (addr == ADDR_W'(MASK_ADDR))  st_d.mask  = wdata[NUM_SRC:1];
            if (addr == ADDR_W'(WVEC_ADDR))  st_d.wvec  = wdata[VEC_W-1:0];
            if (addr == ADDR_W'(SVEC0_ADDR)) st_d.svec0 = wdata[VEC_W-1:0];
            if (addr == ADDR_W'(SVEC1_ADDR)) st_d.svec1 = wdata[VEC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i <= NUM_SRC; i++)
                st_q.ctl[i] <= ctl_reset_value(i);
            st_q.mask  <= '1;
            st_q.pend  <= '0;
            st_q.wvec  <= VEC_RST;
            st_q.svec0 <= VEC_RST;
            st_q.svec1 <= VEC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (addr == ADDR_W'(CTL_BASE + i - 1))
                rdata = DATA_W'(st_q.ctl[i]);
        end
        if (addr == ADDR_W'(MASK_ADDR)) rdata[NUM_SRC:1] = st_q.mask;
        if (addr == ADDR_W'(PEND_ADDR)) rdata[NUM_SRC:1] = st_q.pend;
        if (addr == ADDR_W'(WVEC_ADDR))  rdata = DATA_W'(st_q.wvec);
        if (addr == ADDR_W'(SVEC0_ADDR)) rdata = DATA_W'(st_q.svec0);
        if (addr == ADDR_W'(SVEC1_ADDR)) rdata = DATA_W'(st_q.svec1);
    end

    assign ctl_o   = st_q.ctl;
    assign mask_o  = st_q.mask;
    assign pend_o  = st_q.pend;
    assign wvec_o  = st_q.wvec;
    assign svec0_o = st_q.svec0;
    assign svec1_o = st_q.svec1;

    // R1: pending mirrors the request level of the previous edge
    p_pend_tracks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_o == $past(irq_req)));

    // R2: a mask write lands on the next edge
    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(MASK_ADDR)) |=> (mask_o == $past(wdata[NUM_SRC:1])));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int PRI_W   = 5,
    parameter int MIN_PRI = 4,
    localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1][CTL_W-1:0] ctl,
    input  logic [NUM_SRC:1]            mask,
    input  logic [NUM_SRC:1]            pend,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_idx,
    output logic [CTL_W-1:0]            win_ctl
);

    logic [NUM_SRC:1] active;
    logic [PRI_W-1:0] best;

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_active
        assign active[g] = pend[g] & ~mask[g];
    end

    // Ascending scan with strict compare: lower index keeps a tie
    always_comb begin
        best    = '0;
        win_idx = '0;
        win_ctl = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (active[i] && (ctl[i][PRI_W-1:0] > best)) begin
                best    = ctl[i][PRI_W-1:0];
                win_idx = IDX_W'(i);
                win_ctl = ctl[i];
            end
        end
        win_valid = (best >= PRI_W'(MIN_PRI));
    end

endmodule

// File: rtl/irqc_vecgen.sv
module irqc_vecgen
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 13,
    parameter int WDOG_SRC  = 8,
    parameter int SER0_SRC  = 12,
    parameter int SER1_SRC  = 13,
    parameter int AUTO_BASE = 24,
    parameter logic [VEC_W-1:0] FALLBACK_VEC = 8'h0F,
    localparam int IDX_W    = $clog2(NUM_SRC + 1)
) (
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [CTL_W-1:0]  win_ctl,
    input  logic [VEC_W-1:0]  wvec,
    input  logic [VEC_W-1:0]  svec0,
    input  logic [VEC_W-1:0]  svec1,
    output irq_out_t          out_d
);

    localparam int AUTO_BIT = CTL_W - 1;

    always_comb begin
        out_d = '0;
        if (win_valid) begin
            out_d.level = win_ctl[LVL_W+1:2];
            if (win_ctl[AUTO_BIT])
                out_d.vector = VEC_W'(AUTO_BASE) + VEC_W'(out_d.level);
            else if (win_idx == IDX_W'(WDOG_SRC))
                out_d.vector = wvec;
            else if (win_idx == IDX_W'(SER0_SRC))
                out_d.vector = svec0;
            else if (win_idx == IDX_W'(SER1_SRC))
                out_d.vector = svec1;
            else
                out_d.vector = FALLBACK_VEC;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 13,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int MIN_PRI   = 4,
    parameter int AUTO_BASE = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_req_i,
    input  logic                reg_wr_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic [LVL_W-1:0]    irq_level_o,
    output logic [VEC_W-1:0]    irq_vector_o
);

    localparam int IDX_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1][CTL_W-1:0] ctl;
    logic [NUM_SRC:1]            mask;
    logic [NUM_SRC:1]            pend;
    logic [VEC_W-1:0]            wvec, svec0, svec1;
    logic                        win_valid;
    logic [IDX_W-1:0]            win_idx;
    logic [CTL_W-1:0]            win_ctl;
    irq_out_t                    out_d, out_q;

    irqc_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req_i),
        .wr_en   (reg_wr_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .rdata   (reg_rdata_o),
        .ctl_o   (ctl),
        .mask_o  (mask),
        .pend_o  (pend),
        .wvec_o  (wvec),
        .svec0_o (svec0),
        .svec1_o (svec1)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .MIN_PRI(MIN_PRI)) u_arb (
        .ctl       (ctl),
        .mask      (mask),
        .pend      (pend),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_ctl   (win_ctl)
    );

    irqc_vecgen #(.NUM_SRC(NUM_SRC), .AUTO_BASE(AUTO_BASE)) u_vec (
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_ctl   (win_ctl),
        .wvec      (wvec),
        .svec0     (svec0),
        .svec1     (svec1),
        .out_d     (out_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_level_o  = out_q.level;
    assign irq_vector_o = out_q.vector;

    // R2: the granted source is pending and not masked
    p_no_masked_winner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend[win_idx] && !mask[win_idx]));

    // R4: without a qualified winner the outputs go idle next cycle
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> (irq_level_o == '0 && irq_vector_o == '0));

    // R4: a zero level never carries a vector
    p_zero_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o == '0) |-> (irq_vector_o == '0));

    // R5: the level follows the winner's field one cycle later
    p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> (irq_level_o == $past(win_ctl[LVL_W+1:2])));

    // R6: autovector form
    p_autovec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_ctl[CTL_W-1]) |=>
            (irq_vector_o == VEC_W'(AUTO_BASE) + VEC_W'(irq_level_o)));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] req = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [2:0]  level;
    logic [7:0]  vector;

    int tests = 0;
    int fails = 0;

    logic [7:0]  ctl_m [1:13];
    logic [13:1] mask_m;
    logic [7:0]  wv_m, s0_m, s1_m;

    always #10 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_req_i    (req),
        .reg_wr_i     (wr),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_level_o  (level),
        .irq_vector_o (vector)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        if (a >= 8'h14 && a <= 8'h20) ctl_m[a - 8'h13] = d[7:0];
        if (a == 8'h36) mask_m = d[13:1];
        if (a == 8'h40) wv_m = d[7:0];
        if (a == 8'h41) s0_m = d[7:0];
        if (a == 8'h42) s1_m = d[7:0];
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Expected level/vector computed from the requirement text
    task automatic model(input logic [12:0] r, output logic [2:0] lv, output logic [7:0] vc);
        int best = 0;
        int w = 0;
        for (int i = 1; i <= 13; i++) begin
            if (r[i-1] && !mask_m[i] && int'(ctl_m[i] % 32) > best) begin
                best = int'(ctl_m[i] % 32);
                w = i;
            end
        end
        if (best < 4) begin
            lv = 0; vc = 0;
        end else begin
            lv = 3'((ctl_m[w] / 4) % 8);
            if (ctl_m[w] >= 8'h80)      vc = 8'(24 + lv);
            else if (w == 8)            vc = wv_m;
            else if (w == 12)           vc = s0_m;
            else if (w == 13)           vc = s1_m;
            else                        vc = 8'h0F;
        end
    endtask

    task automatic settle_check(input string tag);
        logic [2:0] el;
        logic [7:0] ev;
        repeat (2) @(posedge clk);
        @(negedge clk);
        model(req, el, ev);
        check({tag, " level"}, 16'(level), 16'(el));
        check({tag, " vector"}, 16'(vector), 16'(ev));
    endtask

    initial begin
        #(20 * 150000);
        tests++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        for (int i = 1; i <= 13; i++)
            ctl_m[i] = (i <= 7) ? 8'(i * 4) : (i == 8) ? 8'h1C : (i <= 11) ? 8'h80 : 8'h00;
        mask_m = '1; wv_m = 8'h0F; s0_m = 8'h0F; s1_m = 8'h0F;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R4 reset level", 16'(level), 16'h0);
        check("R4 reset vector", 16'(vector), 16'h0);
        for (int i = 1; i <= 13; i++) begin
            rd_reg(8'(8'h13 + i), d);
            check($sformatf("R8 reset ctl src%0d", i), d, 16'(ctl_m[i]));
        end
        rd_reg(8'h36, d); check("R2 reset mask", d, 16'h3FFE);
        rd_reg(8'h3A, d); check("R1 reset pending", d, 16'h0000);
        rd_reg(8'h40, d); check("R8 reset watchdog vec", d, 16'h000F);
        rd_reg(8'h41, d); check("R8 reset serial0 vec", d, 16'h000F);
        rd_reg(8'h42, d); check("R8 reset serial1 vec", d, 16'h000F);

        // R2: all sources pending but masked: nothing presented
        req = '1;
        settle_check("R2 all masked");
        rd_reg(8'h3A, d); check("R1 pending all", d, 16'h3FFE);
        req = '0;

        // R1: a write to pending does nothing
        wr_reg(8'h3A, 16'hFFFF);
        rd_reg(8'h3A, d); check("R1 pending write ignored", d, 16'h0000);

        // R10: unmapped read and write
        rd_reg(8'h30, d); check("R10 unmapped read", d, 16'h0000);
        wr_reg(8'h30, 16'h00FF);
        rd_reg(8'h14, d); check("R10 ctl1 untouched", d, 16'h0004);
        rd_reg(8'h36, d); check("R10 mask untouched", d, 16'h3FFE);

        // Distinct vector registers for R7
        wr_reg(8'h40, 16'h00A5);
        wr_reg(8'h41, 16'h003C);
        wr_reg(8'h42, 16'h00C3);
        rd_reg(8'h41, d); check("R7 serial0 vec readback", d, 16'h003C);
        wr_reg(8'h36, 16'h0000);

        // R9: request latency, two edges
        wr_reg(8'h16, 16'h0014);
        @(negedge clk); req = 13'b1 << 2;
        @(posedge clk); @(negedge clk);
        check("R9 req not yet visible", 16'(level), 16'h0);
        @(posedge clk); @(negedge clk);
        check("R9 req visible level", 16'(level), 16'h5);
        check("R9 req visible vector", 16'(vector), 16'h0F);
        // R9: register write latency, one edge after the write edge
        @(negedge clk); wr = 1'b1; addr = 8'h16; wdata = 16'h0098;
        @(posedge clk); @(negedge clk); wr = 1'b0; ctl_m[3] = 8'h98;
        check("R9 write not yet visible", 16'(level), 16'h5);
        @(posedge clk); @(negedge clk);
        check("R9 write visible level", 16'(level), 16'h6);
        check("R6 write visible vector", 16'(vector), 16'd30);
        req = '0;

        // Single-source sweep: every source x every rank (R3..R7)
        for (int s = 1; s <= 13; s++) begin
            req = 13'(1) << (s - 1);
            for (int p = 0; p < 32; p++) begin
                wr_reg(8'(8'h13 + s), 16'(((p % 2) * 128) + p));
                settle_check($sformatf("R4 R5 R6 R7 single src%0d rank%0d", s, p));
            end
            req = '0;
        end

        // Pair sweep: ties go to the lower index, else larger rank (R3)
        for (int a = 1; a <= 13; a++) begin
            for (int b = a + 1; b <= 13; b++) begin
                wr_reg(8'(8'h13 + a), 16'h0010);
                wr_reg(8'(8'h13 + b), 16'h0090);
                req = (13'(1) << (a - 1)) | (13'(1) << (b - 1));
                settle_check($sformatf("R3 tie %0d/%0d", a, b));
                wr_reg(8'(8'h13 + b), 16'h0094);
                settle_check($sformatf("R3 higher %0d/%0d", a, b));
                req = '0;
            end
        end

        // Walking mask with all requests high (R2)
        for (int i = 1; i <= 13; i++) wr_reg(8'(8'h13 + i), 16'(4 + i));
        req = '1;
        for (int k = 1; k <= 13; k++) begin
            wr_reg(8'h36, 16'(~(16'(1) << k)) & 16'h3FFE);
            settle_check($sformatf("R2 only src%0d open", k));
            wr_reg(8'h36, 16'(16'(1) << k));
            settle_check($sformatf("R2 src%0d masked", k));
        end
        req = '0;

        finish_run();
    end

endmodule